// File: doc/BRIEF.md
# Compressed Line Writeback Overflow Manager

This block decides what happens to one page's metadata when a compressed cache line is written back. The block receives the index of the line and its new compressed byte count. It maps the byte count to one of four size bins and compares that bin with the bin the line currently holds. If the new data fits the current bin, the line is rewritten where it is. If the new data needs less room, the new smaller bin is recorded and the page is flagged as a candidate for later repacking. No data moves in that case. If the new data needs a larger bin, the line has overflowed.

An overflowing line is placed in the page's spare region for grown lines if that region has a free 64-byte slot and a free pointer. If the region is full, the page is given one more 512-byte chunk, provided the chunk and grown-line caps still allow it. If neither is possible, the block asks for a full recompaction of the page. The block is purely a decision and bookkeeping stage. It takes the page metadata in and gives back the updated metadata, an action code and the repack-candidate flag, one clock later.

Top module: `irm_overflow_mgr`

## Requirements
- R1: The byte count maps to the smallest bin that holds it. Bin code 0 is 0 bytes (count 0). Code 1 is 8 bytes (1 to 8). Code 2 is 32 bytes (9 to 32). Code 3 is 64 bytes (33 and above, so any count over 64 is also code 3).
- R2: A new bin code above the current one is an overflow. A lower code is an underflow. An equal code is no change. Both underflow and no change give action 00 and write the new code into the line's 2-bit field, at bits [2*line+1:2*line] of the bin vector.
- R3: The action code is 00 for rewrite in place, 01 for placement in the spare region, 10 for a new chunk and 11 for a repack request. A nonzero code appears only for an overflow.
- R4: An overflow takes action 01 when the free spare bytes are at least 64 and the grown-line count is below MAX_INFL. The free bytes then drop by 64, the grown-line count rises by 1 and the line gets its new code.
- R5: If R4 does not apply, an overflow takes action 10 when the chunk count is below MAX_CHUNKS and the grown-line count is below MAX_INFL. The chunk count then rises by 1, the grown-line count rises by 1, the free bytes rise by 448 (512 - 64) and the line gets its new code.
- R6: An overflow that meets neither R4 nor R5 takes action 11 and returns every metadata field unchanged, including the line's own code.
- R7: The repack-candidate flag is 1 exactly for an underflow. An underflow leaves the chunk count, the grown-line count and the free bytes unchanged.
- R8: The bin fields of all lines other than the requested one leave unchanged.
- R9: A request accepted on a clock edge gives a response valid for exactly one cycle after that edge. Without a request, rsp_valid_o is low and all other outputs hold their values.
- R10: During reset, rsp_valid_o, the action, the flag and all metadata outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid_i | input | 1 | Writeback request present |
| req_line_i | input | 6 | Index of the line in the page |
| req_bytes_i | input | 7 | New compressed size in bytes |
| meta_bins_i | input | 128 | Current 2-bit bin code of every line |
| meta_chunks_i | input | 4 | 512-byte chunks held by the page |
| meta_infl_i | input | 5 | Lines held in the spare region |
| meta_room_i | input | 13 | Free bytes in the spare region |
| rsp_valid_o | output | 1 | Response present |
| rsp_action_o | output | 2 | Action code |
| rsp_repack_cand_o | output | 1 | Underflow seen, page worth repacking |
| meta_bins_o | output | 128 | Updated bin codes |
| meta_chunks_o | output | 4 | Updated chunk count |
| meta_infl_o | output | 5 | Updated grown-line count |
| meta_room_o | output | 13 | Updated free spare bytes |

## Verification
The bench builds the block with its default parameters: 64 lines, a cap of 8 chunks, a cap of 17 grown lines, 512-byte chunks and 64-byte slots. The metadata is an input, so the bench can drive the counts directly to the cap values. This puts each cap boundary within reach in a single request: a chunk count of 7 against 8, a grown-line count of 16 against 17, and free bytes of 63 against 64. The bench also sweeps every byte count from 0 to 100 to cover each bin edge.

// File: rtl/irm_pkg.sv
package irm_pkg;

  typedef enum logic [1:0] {
    BIN_0B  = 2'd0,
    BIN_8B  = 2'd1,
    BIN_32B = 2'd2,
    BIN_64B = 2'd3
  } bin_e;

  typedef enum logic [1:0] {
    ACT_INPLACE = 2'b00,
    ACT_ROOM    = 2'b01,
    ACT_GROW    = 2'b10,
    ACT_REPACK  = 2'b11
  } act_e;

  // smallest bin that holds a byte count
  function automatic bin_e size_to_bin(input logic [6:0] nbytes);
    if (nbytes == 7'd0)       return BIN_0B;
    else if (nbytes <= 7'd8)  return BIN_8B;
    else if (nbytes <= 7'd32) return BIN_32B;
    else                      return BIN_64B;
  endfunction

endpackage

// File: rtl/irm_size_bin.sv
module irm_size_bin
  import irm_pkg::*;
#(
  parameter int BYTE_W = 7
) (
  input  logic [BYTE_W-1:0] nbytes_i,
  output bin_e              bin_o
);
  logic [6:0] clamped;

  generate
    if (BYTE_W > 7) begin : g_wide
      assign clamped = (nbytes_i > BYTE_W'(127)) ? 7'd127 : nbytes_i[6:0];
    end else begin : g_narrow
      assign clamped = 7'(nbytes_i);
    end
  endgenerate

  assign bin_o = size_to_bin(clamped);
endmodule

// File: rtl/irm_decide.sv
module irm_decide
  import irm_pkg::*;
#(
  parameter int MAX_CHUNKS  = 8,
  parameter int MAX_INFL    = 17,
  parameter int CHUNK_BYTES = 512,
  parameter int SLOT_BYTES  = 64,
  parameter int CHUNK_W     = $clog2(MAX_CHUNKS + 1),
  parameter int INFL_W      = $clog2(MAX_INFL + 1),
  parameter int ROOM_W      = $clog2(MAX_CHUNKS * CHUNK_BYTES + 1)
) (
  input  bin_e                cur_bin_i,
  input  bin_e                new_bin_i,
  input  logic [CHUNK_W-1:0]  chunks_i,
  input  logic [INFL_W-1:0]   infl_i,
  input  logic [ROOM_W-1:0]   room_i,
  output act_e                act_o,
  output logic                ovf_o,
  output logic                udf_o,
  output logic [CHUNK_W-1:0]  chunks_o,
  output logic [INFL_W-1:0]   infl_o,
  output logic [ROOM_W-1:0]   room_o
);
  localparam logic [ROOM_W-1:0]  SLOT     = ROOM_W'(SLOT_BYTES);
  localparam logic [ROOM_W-1:0]  GROW_ADD = ROOM_W'(CHUNK_BYTES - SLOT_BYTES);
  localparam logic [CHUNK_W-1:0] CH_CAP   = CHUNK_W'(MAX_CHUNKS);
  localparam logic [INFL_W-1:0]  IN_CAP   = INFL_W'(MAX_INFL);

  logic ptr_free, room_ok, grow_ok;

  assign ovf_o    = new_bin_i > cur_bin_i;
  assign udf_o    = new_bin_i < cur_bin_i;
  assign ptr_free = infl_i < IN_CAP;
  assign room_ok  = ptr_free && (room_i >= SLOT);
  assign grow_ok  = ptr_free && (chunks_i < CH_CAP);

  always_comb begin
    act_o    = ACT_INPLACE;
    chunks_o = chunks_i;
    infl_o   = infl_i;
    room_o   = room_i;
    if (ovf_o) begin
      if (room_ok) begin
        act_o  = ACT_ROOM;
        infl_o = infl_i + INFL_W'(1);
        room_o = room_i - SLOT;
      end else if (grow_ok) begin
        act_o    = ACT_GROW;
        chunks_o = chunks_i + CHUNK_W'(1);
        infl_o   = infl_i + INFL_W'(1);
        room_o   = room_i + GROW_ADD;
      end else begin
        act_o = ACT_REPACK;
      end
    end
  end
endmodule

// File: rtl/irm_overflow_mgr.sv
module irm_overflow_mgr
  import irm_pkg::*;
#(
  parameter int LINES       = 64,
  parameter int BYTE_W      = 7,
  parameter int MAX_CHUNKS  = 8,
  parameter int MAX_INFL    = 17,
  parameter int CHUNK_BYTES = 512,
  parameter int SLOT_BYTES  = 64,
  parameter int LINE_W      = $clog2(LINES),
  parameter int BINS_W      = 2 * LINES,
  parameter int CHUNK_W     = $clog2(MAX_CHUNKS + 1),
  parameter int INFL_W      = $clog2(MAX_INFL + 1),
  parameter int ROOM_W      = $clog2(MAX_CHUNKS * CHUNK_BYTES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid_i,
  input  logic [LINE_W-1:0]  req_line_i,
  input  logic [BYTE_W-1:0]  req_bytes_i,
  input  logic [BINS_W-1:0]  meta_bins_i,
  input  logic [CHUNK_W-1:0] meta_chunks_i,
  input  logic [INFL_W-1:0]  meta_infl_i,
  input  logic [ROOM_W-1:0]  meta_room_i,
  output logic               rsp_valid_o,
  output logic [1:0]         rsp_action_o,
  output logic               rsp_repack_cand_o,
  output logic [BINS_W-1:0]  meta_bins_o,
  output logic [CHUNK_W-1:0] meta_chunks_o,
  output logic [INFL_W-1:0]  meta_infl_o,
  output logic [ROOM_W-1:0]  meta_room_o
);
  localparam logic [ROOM_W-1:0]  SLOT   = ROOM_W'(SLOT_BYTES);
  localparam logic [CHUNK_W-1:0] CH_CAP = CHUNK_W'(MAX_CHUNKS);

  // named internal events
  bin_e               cur_bin, new_bin;
  act_e               dec_act;
  logic               dec_ovf, dec_udf, write_bin;
  logic [CHUNK_W-1:0] nxt_chunks;
  logic [INFL_W-1:0]  nxt_infl;
  logic [ROOM_W-1:0]  nxt_room;
  logic [BINS_W-1:0]  nxt_bins;

  assign cur_bin   = bin_e'(meta_bins_i[2*req_line_i +: 2]);
  assign write_bin = dec_act != ACT_REPACK;

  irm_size_bin #(.BYTE_W(BYTE_W)) u_bin (
    .nbytes_i (req_bytes_i),
    .bin_o    (new_bin)
  );

  irm_decide #(
    .MAX_CHUNKS (MAX_CHUNKS), .MAX_INFL (MAX_INFL),
    .CHUNK_BYTES(CHUNK_BYTES), .SLOT_BYTES(SLOT_BYTES),
    .CHUNK_W(CHUNK_W), .INFL_W(INFL_W), .ROOM_W(ROOM_W)
  ) u_dec (
    .cur_bin_i (cur_bin),
    .new_bin_i (new_bin),
    .chunks_i  (meta_chunks_i),
    .infl_i    (meta_infl_i),
    .room_i    (meta_room_i),
    .act_o     (dec_act),
    .ovf_o     (dec_ovf),
    .udf_o     (dec_udf),
    .chunks_o  (nxt_chunks),
    .infl_o    (nxt_infl),
    .room_o    (nxt_room)
  );

  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign nxt_bins[2*g +: 2] =
      (write_bin && (req_line_i == LINE_W'(g))) ? new_bin : meta_bins_i[2*g +: 2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_o       <= 1'b0;
      rsp_action_o      <= 2'b00;
      rsp_repack_cand_o <= 1'b0;
      meta_bins_o       <= '0;
      meta_chunks_o     <= '0;
      meta_infl_o       <= '0;
      meta_room_o       <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        rsp_action_o      <= dec_act;
        rsp_repack_cand_o <= dec_udf;
        meta_bins_o       <= nxt_bins;
        meta_chunks_o     <= nxt_chunks;
        meta_infl_o       <= nxt_infl;
        meta_room_o       <= nxt_room;
      end
    end
  end

  // assertions
  a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i |-> $onehot0({dec_ovf, dec_udf}));

  a_r3_code_needs_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && dec_act != ACT_INPLACE) |-> dec_ovf);

  a_r4_room_step: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && !rst_n == 1'b0) |=>
      (rsp_action_o != 2'b01 || meta_room_o == $past(meta_room_i) - SLOT));

  a_r5_grow_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && dec_act == ACT_GROW) |-> (meta_chunks_i < CH_CAP));

  a_r6_repack_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && dec_act == ACT_REPACK) |=> (meta_bins_o == $past(meta_bins_i)));

  a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i |=> rsp_valid_o);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid_i |=> ($stable(rsp_action_o) && $stable(meta_bins_o) && !rsp_valid_o));
endmodule

// File: tb/irm_overflow_mgr_tb.sv
module irm_overflow_mgr_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic         req_valid;
  logic [5:0]   req_line;
  logic [6:0]   req_bytes;
  logic [127:0] bins_i, bins_o;
  logic [3:0]   ch_i, ch_o;
  logic [4:0]   inf_i, inf_o;
  logic [12:0]  room_i, room_o;
  logic         rsp_valid, cand;
  logic [1:0]   act;

  irm_overflow_mgr dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid), .req_line_i(req_line), .req_bytes_i(req_bytes),
    .meta_bins_i(bins_i), .meta_chunks_i(ch_i), .meta_infl_i(inf_i), .meta_room_i(room_i),
    .rsp_valid_o(rsp_valid), .rsp_action_o(act), .rsp_repack_cand_o(cand),
    .meta_bins_o(bins_o), .meta_chunks_o(ch_o), .meta_infl_o(inf_o), .meta_room_o(room_o)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  task automatic check(input string tag, input logic [127:0] got, input logic [127:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  typedef struct packed {
    logic [5:0]  line;
    logic [6:0]  nbytes;
    logic [1:0]  cur;
    logic [3:0]  ch;
    logic [4:0]  inf;
    logic [12:0] room;
    logic [1:0]  eact;
    logic [1:0]  ebin;
    logic [3:0]  ech;
    logic [4:0]  einf;
    logic [12:0] eroom;
    logic        eudf;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{6'd0,  7'd0,   2'd0, 4'd2, 5'd0,  13'd448, 2'b00, 2'd0, 4'd2, 5'd0,  13'd448, 1'b0},
    '{6'd5,  7'd8,   2'd1, 4'd2, 5'd0,  13'd448, 2'b00, 2'd1, 4'd2, 5'd0,  13'd448, 1'b0},
    '{6'd7,  7'd9,   2'd1, 4'd2, 5'd0,  13'd448, 2'b01, 2'd2, 4'd2, 5'd1,  13'd384, 1'b0},
    '{6'd63, 7'd64,  2'd2, 4'd2, 5'd3,  13'd32,  2'b10, 2'd3, 4'd3, 5'd4,  13'd480, 1'b0},
    '{6'd10, 7'd33,  2'd2, 4'd4, 5'd16, 13'd64,  2'b01, 2'd3, 4'd4, 5'd17, 13'd0,   1'b0},
    '{6'd11, 7'd40,  2'd1, 4'd7, 5'd16, 13'd0,   2'b10, 2'd3, 4'd8, 5'd17, 13'd448, 1'b0},
    '{6'd12, 7'd20,  2'd1, 4'd8, 5'd2,  13'd0,   2'b11, 2'd1, 4'd8, 5'd2,  13'd0,   1'b0},
    '{6'd13, 7'd20,  2'd1, 4'd3, 5'd17, 13'd200, 2'b11, 2'd1, 4'd3, 5'd17, 13'd200, 1'b0},
    '{6'd14, 7'd0,   2'd3, 4'd3, 5'd4,  13'd100, 2'b00, 2'd0, 4'd3, 5'd4,  13'd100, 1'b1},
    '{6'd20, 7'd32,  2'd3, 4'd1, 5'd0,  13'd0,   2'b00, 2'd2, 4'd1, 5'd0,  13'd0,   1'b1},
    '{6'd21, 7'd100, 2'd2, 4'd2, 5'd0,  13'd448, 2'b01, 2'd3, 4'd2, 5'd1,  13'd384, 1'b0},
    '{6'd30, 7'd1,   2'd0, 4'd4, 5'd5,  13'd63,  2'b10, 2'd1, 4'd5, 5'd6,  13'd511, 1'b0},
    '{6'd31, 7'd64,  2'd3, 4'd1, 5'd1,  13'd0,   2'b00, 2'd3, 4'd1, 5'd1,  13'd0,   1'b0}
  };

  localparam logic [127:0] BG = {64{2'b10}};

  function automatic logic [1:0] ref_bin(input int n);
    if (n < 1) return 2'd0;
    if (n < 9) return 2'd1;
    if (n < 33) return 2'd2;
    return 2'd3;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R9 got=hung exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [127:0] lastbins;
    req_valid = 0; req_line = 0; req_bytes = 0;
    bins_i = BG; ch_i = 0; inf_i = 0; room_i = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 valid", 128'(rsp_valid), 128'd0);
    check("R10 action", 128'(act), 128'd0);
    check("R10 bins", bins_o, 128'd0);
    check("R10 counts", {ch_o, inf_o, room_o, cand}, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [127:0] eb;
      bins_i = BG;
      bins_i[2*VEC[i].line +: 2] = VEC[i].cur;
      eb = BG;
      eb[2*VEC[i].line +: 2] = VEC[i].ebin;
      req_valid = 1; req_line = VEC[i].line; req_bytes = VEC[i].nbytes;
      ch_i = VEC[i].ch; inf_i = VEC[i].inf; room_i = VEC[i].room;
      @(negedge clk);
      check("R9 valid", 128'(rsp_valid), 128'd1);
      check("R3 R4 R5 R6 action", 128'(act), 128'(VEC[i].eact));
      check("R2 R8 bins", bins_o, eb);
      check("R4 R5 chunks", 128'(ch_o), 128'(VEC[i].ech));
      check("R4 R5 infl", 128'(inf_o), 128'(VEC[i].einf));
      check("R4 R5 R6 room", 128'(room_o), 128'(VEC[i].eroom));
      check("R7 flag", 128'(cand), 128'(VEC[i].eudf));
    end

    // R9: no request -> outputs hold, valid low
    lastbins = bins_o;
    req_valid = 0; req_line = 6'd3; req_bytes = 7'd50; bins_i = '0; room_i = 13'd999;
    @(negedge clk);
    check("R9 idle valid", 128'(rsp_valid), 128'd0);
    check("R9 idle bins", bins_o, lastbins);
    check("R9 idle room", 128'(room_o), 128'd0);

    // R1 sweep: line 3 at code 3, never an overflow
    for (int n = 0; n <= 100; n++) begin
      bins_i = '0; bins_i[7:6] = 2'd3;
      req_valid = 1; req_line = 6'd3; req_bytes = 7'(n);
      ch_i = 4'd8; inf_i = 5'd17; room_i = 13'd0;
      @(negedge clk);
      check("R1 bin", 128'(bins_o[7:6]), 128'(ref_bin(n)));
    end
    req_valid = 0;
    @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule